// File: doc/BRIEF.md
# Cycle-Counter Tap Event Generator

A free-running cycle counter and a control word together produce periodic pulses. Two kinds of output are derived from the counter bits. A toggle of a selectable low-order bit drives a small reloadable down-counter, the post-scaler. Each time the post-scaler is at zero when a toggle arrives, it produces one pulse, which is either a sampling event or a cycle-count event. A toggle of a selectable high-order bit produces a synchronization request pulse for a downstream trace formatter.

Software writes the control word or the counter through a single write strobe with a one-bit select. Both values can be read back at all times on two dedicated read buses. A clock-enable input qualifies each increment, and an external permit input gates the synchronization requests. The stored counter-enable bit is held as a three-state run machine:
- RS_HALT: the counter is stopped.
- RS_RUN: the counter advances.
- RS_ABSENT: used when the build parameter declares no counter. The machine never leaves this state.

Two transitions exist: RS_HALT goes to RS_RUN on a control write with bit 0 set, and RS_RUN goes to RS_HALT on a control write with bit 0 clear.

Top module: `cyc_tap_evgen`

## Requirements
- R1: While control bit 0 reads 1 and `tick_en` is high, the counter advances by one per cycle. Otherwise it holds. A write with `reg_sel`=1 loads `reg_wdata` into the counter, and that write takes priority over the increment.
- R2: With parameter `NO_COUNTER`=1, control bit 25 reads 1, bit 0 reads 0 whatever is written, the counter never advances and no pulse is produced. With `NO_COUNTER`=0, bit 25 reads 0.
- R3: Control bit 9 picks the low tap: 0 selects counter bit 6 and 1 selects bit 10. A tap change is a cycle in which the selected bit differs from its own value in the previous cycle, in either direction. This includes a change caused by a counter write. A tap change counts only while bit 0 reads 1.
- R4: The post-scaler sits in control bits 8:5 and the preset in bits 4:1. On a tap change, a nonzero post-scaler decrements. A zero post-scaler fires an event and reloads from the preset. A preset of 0 therefore fires on every change and a preset of 1 fires on every other change.
- R5: A fired event drives `sample_pulse` when bit 12 is 1. It drives `cyc_evt_pulse` only when bit 12 is 0 and bit 22 is 1. The pulse is high in the cycle after the tap-change cycle.
- R6: Control bits 11:10 select the sync tap: 0 means none, 1 means counter bit 24, 2 means bit 26 and 3 means bit 28. Either transition of the selected bit gives one `sync_pulse`, high in the cycle after the change.
- R7: A sync pulse requires both bit 0 reading 1 and `sync_allow` high in the change cycle.
- R8: The control word resets to 0x4000_0000. Only bits 22, 12, 11:10, 9, 8:5, 4:1 and 0 are writable. All other bits keep their reset values, except bit 25, which follows R2.
- R9: The post-scaler can be read in bits 8:5. A control write loads it from `reg_wdata[8:5]`, and a tap change in the same cycle is then dropped.
- R10: All pulses are registered and reset to 0. `sample_pulse` and `cyc_evt_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Qualifies each counter increment |
| sync_allow | input | 1 | External permit for sync requests |
| reg_wr | input | 1 | Write strobe |
| reg_sel | input | 1 | Write target: 0 = control word, 1 = counter |
| reg_wdata | input | 32 | Write data |
| ctrl_rdata | output | 32 | Control word readback |
| count_rdata | output | CNT_W | Counter readback |
| sample_pulse | output | 1 | Sampling event pulse |
| cyc_evt_pulse | output | 1 | Cycle-count event pulse |
| sync_pulse | output | 1 | Synchronization request pulse |

## Verification
The event path is exercised with three patterns:
- Preset 0 with bit 6, which fires on both rising and falling crossings.
- Preset 1 with sampling and cycle events both enabled, which separates the divide ratio from the priority rule.
- A nonzero loaded post-scaler on bit 10, which distinguishes the initial countdown from the reload value.

A counter write that flips the tap bit checks that software-caused changes count. Each sync tap code is run across its own crossing, and the permit is withheld on a crossing that would otherwise fire. A second instance with no counter shows that the enable is read-only and that the reserved bits do not move.

// File: rtl/cyc_tap_pkg.sv
package cyc_tap_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned PS_W       = 4;
    localparam logic [REG_W-1:0] CTRL_RST = 32'h4000_0000;

    localparam int unsigned EN_BIT     = 0;
    localparam int unsigned PRE_LSB    = 1;
    localparam int unsigned PS_LSB     = 5;
    localparam int unsigned LOSEL_BIT  = 9;
    localparam int unsigned SYNC_LSB   = 10;
    localparam int unsigned SAMP_BIT   = 12;
    localparam int unsigned CYC_BIT    = 22;
    localparam int unsigned ABSENT_BIT = 25;

    typedef enum logic [1:0] {
        RS_HALT   = 2'd0,
        RS_RUN    = 2'd1,
        RS_ABSENT = 2'd2
    } run_state_e;

    typedef struct packed {
        logic            samp_en;
        logic            cyc_en;
        logic [1:0]      sync_sel;
        logic            lo_sel;
        logic [PS_W-1:0] preset;
    } ctrl_fields_t;
endpackage

// File: rtl/cyc_tap_run_fsm.sv
module cyc_tap_run_fsm
    import cyc_tap_pkg::*;
#(
    parameter bit ABSENT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic en_wdata,
    output logic running
);
    localparam run_state_e RST_ST = ABSENT ? RS_ABSENT : RS_HALT;

    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_HALT:   if (ctrl_wr && en_wdata)  state_d = RS_RUN;
            RS_RUN:    if (ctrl_wr && !en_wdata) state_d = RS_HALT;
            RS_ABSENT: state_d = RS_ABSENT;
            default:   state_d = RST_ST;
        endcase
    end

    always_comb begin
        running = 1'b0;
        unique case (state_q)
            RS_RUN:  running = 1'b1;
            default: running = 1'b0;
        endcase
    end
endmodule

// File: rtl/cyc_tap_counter.sv
module cyc_tap_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (inc)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cyc_tap_edge.sv
module cyc_tap_edge #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned LSB   = 6,
    parameter int unsigned STEP  = 4,
    parameter int unsigned N     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    output logic [N-1:0]     chg
);
    for (genvar g = 0; g < N; g++) begin : g_tap
        localparam int unsigned POS = LSB + g * STEP;
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= cnt[POS];
        end
        assign chg[g] = cnt[POS] ^ prev_q;
    end
endmodule

// File: rtl/cyc_tap_postscale.sv
module cyc_tap_postscale
    import cyc_tap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ps_wr,
    input  logic [PS_W-1:0] ps_wdata,
    input  logic            tap_hit,
    input  logic [PS_W-1:0] preset,
    input  logic            samp_en,
    input  logic            cyc_en,
    output logic [PS_W-1:0] ps_q,
    output logic            samp_pulse,
    output logic            cyc_pulse
);
    logic fire;
    assign fire = tap_hit && !ps_wr && (ps_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ps_q <= '0;
        else if (ps_wr)   ps_q <= ps_wdata;
        else if (tap_hit) ps_q <= (ps_q == '0) ? preset : ps_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_pulse <= 1'b0;
            cyc_pulse  <= 1'b0;
        end else begin
            samp_pulse <= fire && samp_en;
            cyc_pulse  <= fire && !samp_en && cyc_en;
        end
    end
endmodule

// File: rtl/cyc_tap_evgen.sv
module cyc_tap_evgen
    import cyc_tap_pkg::*;
#(
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned LO_TAP_LSB    = 6,
    parameter int unsigned LO_TAP_STEP   = 4,
    parameter int unsigned SYNC_TAP_LSB  = 24,
    parameter int unsigned SYNC_TAP_STEP = 2,
    parameter bit          NO_COUNTER    = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             sync_allow,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      ctrl_rdata,
    output logic [CNT_W-1:0] count_rdata,
    output logic             sample_pulse,
    output logic             cyc_evt_pulse,
    output logic             sync_pulse
);
    localparam int unsigned LO_N   = 2;
    localparam int unsigned SYNC_N = 3;

    logic          ctrl_wr, cnt_wr, running;
    ctrl_fields_t  fld_q;
    logic [PS_W-1:0]   ps_q;
    logic [LO_N-1:0]   lo_chg;
    logic [SYNC_N-1:0] sync_chg;
    logic          lo_hit, sync_hit;
    logic [1:0]    sync_idx;

    assign ctrl_wr = reg_wr && !reg_sel;
    assign cnt_wr  = reg_wr && reg_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else if (ctrl_wr) begin
            fld_q.samp_en  <= reg_wdata[SAMP_BIT];
            fld_q.cyc_en   <= reg_wdata[CYC_BIT];
            fld_q.sync_sel <= reg_wdata[SYNC_LSB +: 2];
            fld_q.lo_sel   <= reg_wdata[LOSEL_BIT];
            fld_q.preset   <= reg_wdata[PRE_LSB +: PS_W];
        end
    end

    cyc_tap_run_fsm #(.ABSENT(NO_COUNTER)) u_run (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .en_wdata(reg_wdata[EN_BIT]), .running(running)
    );

    cyc_tap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_wr),
        .load_val(reg_wdata[CNT_W-1:0]), .inc(running && tick_en),
        .cnt_q(count_rdata)
    );

    cyc_tap_edge #(.CNT_W(CNT_W), .LSB(LO_TAP_LSB), .STEP(LO_TAP_STEP), .N(LO_N)) u_lo_edge (
        .clk(clk), .rst_n(rst_n), .cnt(count_rdata), .chg(lo_chg)
    );

    cyc_tap_edge #(.CNT_W(CNT_W), .LSB(SYNC_TAP_LSB), .STEP(SYNC_TAP_STEP), .N(SYNC_N)) u_sync_edge (
        .clk(clk), .rst_n(rst_n), .cnt(count_rdata), .chg(sync_chg)
    );

    assign lo_hit   = running && lo_chg[fld_q.lo_sel];
    assign sync_idx = fld_q.sync_sel - 2'd1;
    assign sync_hit = running && sync_allow && (fld_q.sync_sel != 2'd0) && sync_chg[sync_idx];

    cyc_tap_postscale u_ps (
        .clk(clk), .rst_n(rst_n), .ps_wr(ctrl_wr),
        .ps_wdata(reg_wdata[PS_LSB +: PS_W]), .tap_hit(lo_hit),
        .preset(fld_q.preset), .samp_en(fld_q.samp_en), .cyc_en(fld_q.cyc_en),
        .ps_q(ps_q), .samp_pulse(sample_pulse), .cyc_pulse(cyc_evt_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_pulse <= 1'b0;
        else        sync_pulse <= sync_hit;
    end

    always_comb begin
        ctrl_rdata                      = CTRL_RST;
        ctrl_rdata[ABSENT_BIT]          = NO_COUNTER;
        ctrl_rdata[EN_BIT]              = running;
        ctrl_rdata[PRE_LSB +: PS_W]     = fld_q.preset;
        ctrl_rdata[PS_LSB +: PS_W]      = ps_q;
        ctrl_rdata[LOSEL_BIT]           = fld_q.lo_sel;
        ctrl_rdata[SYNC_LSB +: 2]       = fld_q.sync_sel;
        ctrl_rdata[SAMP_BIT]            = fld_q.samp_en;
        ctrl_rdata[CYC_BIT]             = fld_q.cyc_en;
    end
endmodule

// File: rtl/cyc_tap_evgen_chk.sv
module cyc_tap_evgen_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             sync_allow,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [31:0]      ctrl_rdata,
    input logic [CNT_W-1:0] count_rdata,
    input logic             sample_pulse,
    input logic             cyc_evt_pulse,
    input logic             sync_pulse
);
    p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[0] && tick_en && !(reg_wr && reg_sel)) |=> count_rdata == $past(count_rdata) + 1'b1);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rdata[0] && !(reg_wr && reg_sel)) |=> $stable(count_rdata));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pulse || cyc_evt_pulse) |-> ctrl_rdata[8:5] == ctrl_rdata[4:1]);

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_pulse, cyc_evt_pulse}));

    p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_evt_pulse |-> !$past(ctrl_rdata[12]) && $past(ctrl_rdata[22]));

    p_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> $past(ctrl_rdata[11:10]) != 2'b00);

    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> $past(sync_allow) && $past(ctrl_rdata[0]));
endmodule

bind cyc_tap_evgen cyc_tap_evgen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sync_allow(sync_allow),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .ctrl_rdata(ctrl_rdata),
    .count_rdata(count_rdata), .sample_pulse(sample_pulse),
    .cyc_evt_pulse(cyc_evt_pulse), .sync_pulse(sync_pulse)
);

// File: tb/cyc_tap_evgen_tb.sv
module cyc_tap_evgen_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic tick_en = 1'b1, sync_allow = 1'b0;
    logic reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_rdata, count_rdata;
    logic sample_pulse, cyc_evt_pulse, sync_pulse;

    logic nc_wr = 1'b0;
    logic [31:0] nc_wdata = '0;
    logic [31:0] nc_ctrl, nc_count;
    logic nc_samp, nc_cyc, nc_sync;

    cyc_tap_evgen u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sync_allow(sync_allow),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctrl_rdata(ctrl_rdata), .count_rdata(count_rdata),
        .sample_pulse(sample_pulse), .cyc_evt_pulse(cyc_evt_pulse), .sync_pulse(sync_pulse)
    );

    cyc_tap_evgen #(.NO_COUNTER(1'b1)) u_dut_nc (
        .clk(clk), .rst_n(rst_n), .tick_en(1'b1), .sync_allow(1'b1),
        .reg_wr(nc_wr), .reg_sel(1'b0), .reg_wdata(nc_wdata),
        .ctrl_rdata(nc_ctrl), .count_rdata(nc_count),
        .sample_pulse(nc_samp), .cyc_evt_pulse(nc_cyc), .sync_pulse(nc_sync)
    );

    typedef struct { int kind; logic [31:0] cnt; } exp_t;
    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0, nc_seen = 0;
    logic timeout = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [31:0] c);
        exp_t e;
        e.kind = kind; e.cnt = c;
        exp_q.push_back(e);
    endtask

    task automatic see(input int kind);
        exp_t e;
        string req;
        req = (kind == 2) ? "R6 sync" : "R4/R5 event";
        if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL %s unexpected pulse kind=%0d actual cnt=%h expected none", req, kind, count_rdata);
        end else begin
            e = exp_q.pop_front();
            check({req, " kind"}, kind, e.kind);
            check({req, " cnt"}, count_rdata, e.cnt);
        end
    endtask

    // monitor: compares each observed pulse against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (sample_pulse)  see(0);
                if (cyc_evt_pulse) see(1);
                if (sync_pulse)    see(2);
                if (nc_samp || nc_cyc || nc_sync) nc_seen++;
            end
        end
    end

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_cnt(input logic [31:0] v);
        while (count_rdata < v) @(negedge clk);
    endtask

    task automatic run_all();
        logic [31:0] a;
        // reset state
        check("R8 reset ctrl", ctrl_rdata, 32'h4000_0000);
        check("R1 reset count", count_rdata, 32'h0);
        check("R10 reset pulses", {29'h0, sample_pulse, cyc_evt_pulse, sync_pulse}, 32'h0);

        // no-counter instance: read-only enable, reserved bits fixed
        check("R2 nc reset ctrl", nc_ctrl, 32'h4200_0000);
        @(negedge clk); nc_wr = 1'b1; nc_wdata = 32'hFFFF_FFFF;
        @(negedge clk); nc_wr = 1'b0;
        check("R8 R2 nc all-ones readback", nc_ctrl, 32'h4240_1FFE);
        repeat (20) @(negedge clk);
        check("R2 nc count idle", nc_count, 32'h0);

        // T1: bit-6 tap, preset 0, cycle events, both crossing directions
        push(1, 32'd65); push(1, 32'd129); push(1, 32'd193); push(1, 32'd257);
        wr(1'b1, 32'h3C);
        wr(1'b0, 32'h0040_0001);
        @(negedge clk); a = count_rdata;
        repeat (5) @(negedge clk);
        check("R1 increments", count_rdata, a + 32'd5);
        wait_cnt(32'h110);
        wr(1'b0, 32'h0);

        // T2: preset 1, sampling overrides cycle event
        wr(1'b1, 32'h3C);
        push(0, 32'd65); push(0, 32'd193); push(0, 32'd321);
        wr(1'b0, 32'h0040_1003);
        wait_cnt(32'h150);
        check("R9 post-scaler readback", ctrl_rdata, 32'h4040_1023);
        wr(1'b0, 32'h0);
        @(negedge clk); a = count_rdata;
        repeat (20) @(negedge clk);
        check("R1 holds when disabled", count_rdata, a);

        // T3: bit-10 tap, post-scaler loaded with 1, tick_en pause
        wr(1'b1, 32'h3F0);
        push(1, 32'd2049); push(1, 32'd3073);
        wr(1'b0, 32'h0040_0221);
        tick_en = 1'b0;
        @(negedge clk); a = count_rdata;
        repeat (30) @(negedge clk);
        check("R1 holds without tick_en", count_rdata, a);
        tick_en = 1'b1;
        wait_cnt(32'd3100);
        check("R9 R3 ctrl after bit-10 run", ctrl_rdata, 32'h4040_0201);
        wr(1'b0, 32'h0);

        // T4: sync taps
        sync_allow = 1'b1;
        wr(1'b1, 32'h00FF_FFF0);
        push(2, 32'h0100_0001);
        wr(1'b0, 32'h0000_0401);
        wait_cnt(32'h0100_0010);
        wr(1'b0, 32'h0);
        sync_allow = 1'b0;                       // R7: crossing must not fire
        wr(1'b1, 32'h01FF_FFF0);
        wr(1'b0, 32'h0000_0401);
        wait_cnt(32'h0200_0010);
        wr(1'b0, 32'h0);
        sync_allow = 1'b1;
        wr(1'b1, 32'h2FFF_FFF8);
        push(2, 32'h3000_0001);
        wr(1'b0, 32'h0000_0C01);
        wait_cnt(32'h3000_0010);
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h33FF_FFF8);
        push(2, 32'h3400_0001);
        wr(1'b0, 32'h0000_0801);
        wait_cnt(32'h3400_0010);
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0FFF_FFF8);                 // R6: code 0 gives no sync
        wr(1'b0, 32'h0000_0001);
        wait_cnt(32'h1000_0010);
        wr(1'b0, 32'h0);

        // T5: R3 counter write that flips the tap bit counts as a change
        wr(1'b1, 32'h10);
        push(1, 32'h51);
        wr(1'b0, 32'h0040_0001);
        wr(1'b1, 32'h50);
        wait_cnt(32'h60);
        wr(1'b0, 32'h0);
        repeat (5) @(negedge clk);

        check("R4 R6 all expected pulses seen", exp_q.size(), 32'd0);
        check("R2 nc produced no pulse", nc_seen, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin repeat (100000) @(posedge clk); timeout = 1'b1; end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule